// File: doc/BRIEF.md
# Selectable Parallel Prefix Adder

This block adds two unsigned W-bit operands without a carry-in. It returns the W-bit sum and a carry-out. It is meant to serve as the final two-row adder behind a column-compression multiplier tree, where the adder's logarithmic carry depth keeps the whole multiplier's delay logarithmic.

A parameter picks one of three carry-prefix graphs: a dense graph with minimum depth, a sparse up-sweep/down-sweep graph, or a hybrid that runs the dense graph on even positions and fixes odd positions in one extra stage. All three sit behind one port list. The three graphs share the same per-bit generate/propagate front end and the same sum back end, and differ only in which positions combine in each stage and with which partner. Every graph is elaborated from index rules, so any width of at least 2 works, including widths that are not powers of two.

Top module: `pfx_adder`

## Requirements
- R1: For every operand pair, {carryOut, sum} equals opA + opB computed at W+1 bits.
- R2: With TOPO = 0 (dense graph), in every stage k (k = 1..ceil(log2 W)) each position j ≥ 2^(k-1) merges with position j − 2^(k-1), and R1 holds.
- R3: The carry out of bit j is set whenever both operand bits j are 1. It is clear whenever both are 0. Otherwise it equals the carry out of bit j−1, with a zero carry below bit 0.
- R4: With TOPO = 1 (sparse graph), an up-sweep merges block-aligned groups and a down-sweep then completes the remaining positions from the largest span to the smallest, and R1 holds.
- R5: With TOPO = 2 (hybrid graph), even-numbered positions (counting from 1) are merged dense-style and a final stage merges each odd position above 1 with the position just below it, and R1 holds.
- R6: Widths that are not powers of two (for example 5, 14, 30) give correct sums; nodes whose index would exceed the width are dropped.
- R7: Zero plus zero yields a zero sum and a clear carry-out.
- R8: All-ones plus all-ones yields a sum of all ones except bit 0 and a set carry-out.
- R9: Alternating patterns 0101… plus 1010… yield an all-ones sum with a clear carry-out (full propagate, no generate).
- R10: All-ones plus one yields a zero sum and a set carry-out (a carry ripples over the full width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| sum | output | WIDTH | Low WIDTH bits of opA + opB |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The embedded checks assume only that the operand inputs hold settled, defined values whenever the combinational logic is evaluated. The bench guarantees this by changing operands on the falling clock edge and reading results one time unit after the rising edge. There is no state and no timing constraint between operand pairs, so every input pair is legal. Widths 5 and 8 are swept over all operand pairs for all three graphs. Widths 14, 30 and 62 receive random pairs, single-bit generate walks, and the saturating and alternating patterns that stress the longest carry paths.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum int {
    TOPO_DENSE  = 0,
    TOPO_SPARSE = 1,
    TOPO_HYBRID = 2
  } topo_e;

  // Number of prefix stages after the generate/propagate stage.
  function automatic int stageCount(topo_e topo, int lg);
    case (topo)
      TOPO_DENSE:  return lg;
      TOPO_SPARSE: return (lg == 0) ? 0 : 2 * lg - 1;
      default:     return lg + 1;
    endcase
  endfunction

  // Distance to the partner node in stage k (1-based stage index).
  function automatic int spanOf(topo_e topo, int lg, int k);
    case (topo)
      TOPO_DENSE:  return 1 << (k - 1);
      TOPO_SPARSE: return (k <= lg) ? (1 << (k - 1)) : (1 << (2 * lg - k - 1));
      default:     return (k <= lg) ? (1 << (k - 1)) : 1;
    endcase
  endfunction

  // Whether position j (0-based) holds a merge node in stage k.
  function automatic bit isNode(topo_e topo, int lg, int k, int j);
    int n;
    int d;
    n = j + 1;
    d = spanOf(topo, lg, k);
    case (topo)
      TOPO_DENSE:  return j >= d;
      TOPO_SPARSE: begin
        if (k <= lg) return (n % (2 * d)) == 0;
        return ((n % (2 * d)) == d) && (n > 2 * d);
      end
      default: begin
        if (k <= lg) return ((n % 2) == 0) && (n > d);
        return ((n % 2) == 1) && (n >= 3);
      end
    endcase
  endfunction

endpackage

// File: rtl/pfx_pre.sv
module pfx_pre #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] genBit,
  output logic [WIDTH-1:0] propBit,
  output logic [WIDTH-1:0] halfSum
);
  assign genBit  = opA & opB;
  assign propBit = opA | opB;
  assign halfSum = opA ^ opB;
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree #(
  parameter int            WIDTH = 32,
  parameter pfx_pkg::topo_e TOPO = pfx_pkg::TOPO_DENSE
) (
  input  logic [WIDTH-1:0] genBit,
  input  logic [WIDTH-1:0] propBit,
  output logic [WIDTH-1:0] carryVec
);
  localparam int LG  = $clog2(WIDTH);
  localparam int NST = pfx_pkg::stageCount(TOPO, LG);

  for (genvar k = 0; k <= NST; k++) begin : stg
    logic [WIDTH-1:0] g;
    logic [WIDTH-1:0] p;
    if (k == 0) begin : seed
      assign g = genBit;
      assign p = propBit;
    end else begin : merge
      for (genvar j = 0; j < WIDTH; j++) begin : bitPos
        if (pfx_pkg::isNode(TOPO, LG, k, j)) begin : node
          localparam int M = j - pfx_pkg::spanOf(TOPO, LG, k);
          assign g[j] = stg[k-1].g[j] | (stg[k-1].p[j] & stg[k-1].g[M]);
          assign p[j] = stg[k-1].p[j] & stg[k-1].p[M];
        end else begin : pass
          assign g[j] = stg[k-1].g[j];
          assign p[j] = stg[k-1].p[j];
        end
      end
    end
  end

  assign carryVec = stg[NST].g;

  always_comb begin
    for (int j = 0; j < WIDTH; j++) begin
      assert_gen_sets_carry_R3: assert (!genBit[j] || carryVec[j])
        else $error("R3: generate at bit %0d did not set carry", j);
      assert_kill_clears_carry_R3: assert (propBit[j] || !carryVec[j])
        else $error("R3: kill at bit %0d did not clear carry", j);
      if (j > 0) begin
        assert_carry_chain_R3: assert (carryVec[j] ==
            (genBit[j] | (propBit[j] & carryVec[j-1])))
          else $error("R3: carry at bit %0d breaks the chain", j);
      end else begin
        assert_carry_base_R3: assert (carryVec[0] == genBit[0])
          else $error("R3: carry at bit 0 differs from generate");
      end
    end
  end
endmodule

// File: rtl/pfx_post.sv
module pfx_post #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] halfSum,
  input  logic [WIDTH-1:0] carryVec,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  assign sum      = halfSum ^ {carryVec[WIDTH-2:0], 1'b0};
  assign carryOut = carryVec[WIDTH-1];
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
  parameter int             WIDTH = 32,
  parameter pfx_pkg::topo_e TOPO  = pfx_pkg::TOPO_DENSE
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  logic [WIDTH-1:0] genBit;
  logic [WIDTH-1:0] propBit;
  logic [WIDTH-1:0] halfSum;
  logic [WIDTH-1:0] carryVec;

  pfx_pre #(.WIDTH(WIDTH)) u_pre (
    .opA(opA), .opB(opB),
    .genBit(genBit), .propBit(propBit), .halfSum(halfSum)
  );

  pfx_tree #(.WIDTH(WIDTH), .TOPO(TOPO)) u_tree (
    .genBit(genBit), .propBit(propBit), .carryVec(carryVec)
  );

  pfx_post #(.WIDTH(WIDTH)) u_post (
    .halfSum(halfSum), .carryVec(carryVec),
    .sum(sum), .carryOut(carryOut)
  );

  initial begin
    assert_width_min_R6: assert (WIDTH >= 2)
      else $error("R6: width must be at least 2");
  end

  always_comb begin
    assert_total_R1: assert ({carryOut, sum} ==
        ({1'b0, opA} + {1'b0, opB}))
      else $error("R1: sum mismatch");
    assert_zero_R7: assert ((opA != '0) || (opB != '0) ||
        ((sum == '0) && !carryOut))
      else $error("R7: zero operands gave nonzero result");
  end
endmodule

// File: tb/pfx_adder_tb.sv
module pfx_adder_tb;
  import pfx_pkg::*;

  localparam int NW = 5;
  localparam int WL [NW] = '{5, 8, 14, 30, 62};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] res [NW][3];

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  for (genvar wi = 0; wi < NW; wi++) begin : gW
    for (genvar ti = 0; ti < 3; ti++) begin : gT
      localparam int W = WL[wi];
      logic [W-1:0] s;
      logic         c;
      pfx_adder #(.WIDTH(W), .TOPO(topo_e'(ti))) u_dut (
        .opA(opA[W-1:0]), .opB(opB[W-1:0]), .sum(s), .carryOut(c)
      );
      assign res[wi][ti] = {{(63 - W){1'b0}}, c, s};
    end
  end

  function automatic logic [63:0] expSum(int w, logic [63:0] a, logic [63:0] b);
    logic [63:0] mask;
    mask = (64'h1 << w) - 64'h1;
    return (a & mask) + (b & mask);
  endfunction

  function automatic string topoTag(int ti, int w);
    string t;
    t = (ti == 0) ? "R2" : (ti == 1) ? "R4" : "R5";
    if ((w & (w - 1)) != 0) t = {t, "/R6"};
    return {"R1/", t};
  endfunction

  // Applies one operand pair and compares every instance.
  task automatic applyCheck(logic [63:0] a, logic [63:0] b, string extra);
    @(negedge clk);
    opA = a;
    opB = b;
    @(posedge clk);
    #1;
    for (int wi = 0; wi < NW; wi++) begin
      for (int ti = 0; ti < 3; ti++) begin
        logic [63:0] e;
        e = expSum(WL[wi], a, b);
        testsRun++;
        if (res[wi][ti] !== e) begin
          testsFailed++;
          $display("FAIL %s%s W=%0d topo=%0d a=%h b=%h actual=%h expected=%h",
                   topoTag(ti, WL[wi]), extra, WL[wi], ti, a, b, res[wi][ti], e);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R7: zero operands
    applyCheck('0, '0, "/R7");
    // R8: saturating operands
    applyCheck('1, '1, "/R8");
    // R9: alternating, full propagate
    applyCheck({16{4'h5}}, {16{4'hA}}, "/R9");
    applyCheck({16{4'hA}}, {16{4'h5}}, "/R9");
    // R10: carry rippling across the full width
    applyCheck('1, 64'h1, "/R10");
    applyCheck(64'h1, '1, "/R10");
    // R3: single generate walked over every bit, plus kill/propagate mix
    for (int j = 0; j < 62; j++) begin
      applyCheck(64'h1 << j, 64'h1 << j, "/R3");
      applyCheck(~(64'h1 << j), 64'h1, "/R3");
    end
    // Exhaustive for widths 5 and 8 (R2, R4, R5, R6)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        applyCheck(64'(a), 64'(b), "");
      end
    end
    // Random for widths 14, 30 and 62
    for (int r = 0; r < 3000; r++) begin
      applyCheck({$urandom, $urandom}, {$urandom, $urandom}, "");
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: R1 run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule